// File: doc/BRIEF.md
# PCI Configuration Access Port

This block sits on the host side of a chip's I/O space and implements the classic two-register scheme for reaching PCI configuration space. A 32-bit address register at I/O port 0xCF8 selects a bus, a function and a dword register. A four-byte data window at 0xCFC to 0xCFF then turns each byte access into a configuration access at that location. The I/O slave is byte-wide. Every access carries the full port address, so its low two bits pick the byte lane.

Only bus 0 is served. The function register spaces live outside the block, one 256-byte space per function and up to 256 functions. Each function supplies a present flag, a write-accept flag and the read byte at the offset the block presents. The block decodes the target and drives a one-hot byte write enable per function. It returns the read byte one cycle after the read strobe. Any access that cannot be routed fails quietly: a read returns all ones and a write is dropped.

Top module: `cfg_access_port`

## Requirements
- R1: After synchronous reset every byte of the address register reads 0x00, configuration access is disabled, `io_rdata` is 0x00 and no bit of `fn_we` is set.
- R2: A write to port 0xCF8+k (k = 0..3) replaces only bits 8k+7:8k of the address register. The other three lanes keep their value.
- R3: After any address-register write, bits 30:24 and bits 1:0 read back as zero. Writing 0xFF to all four lanes therefore reads back 0xFC, 0xFF, 0xFF, 0x80 on lanes 0 to 3.
- R4: A read of port 0xCF8+k returns lane k of the current address register.
- R5: Data-window accesses reach a function only while address bit 31 (enable) is 1. With the enable at 0, a data read returns 0xFF and a data write sets no `fn_we` bit.
- R6: The target function index is address bits 15:8, equal to device*8+function. The presented byte offset `cfg_offset` is address bits 7:2 followed by the two low bits of the data-window port.
- R7: When address bits 23:16 (bus) are non-zero, data reads return 0xFF and data writes set no `fn_we` bit.
- R8: A data read of a function whose present flag is 1 returns that function's byte at `cfg_offset`. A function that is not present, or whose index is NFUNC or above, returns 0xFF.
- R9: A routed data write sets exactly the `fn_we` bit of the target function, in the cycle of the write strobe, with `cfg_wdata` equal to the written byte, provided that function's write-accept flag is 1. If the flag is 0, no bit is set.
- R10: Accesses to ports outside 0xCF8 to 0xCFF are not claimed. Reads return 0x00, and writes change neither the address register nor `fn_we`.
- R11: `io_rdata` carries the result of a read in the cycle after `io_rd` is sampled high and is 0x00 in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | IO_AW | I/O port address; the low two bits are the byte lane |
| io_wdata | input | 8 | Write byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read byte, registered |
| fn_present | input | NFUNC | Per-function present flag |
| fn_wr_accept | input | NFUNC | Per-function write-accept flag |
| fn_rdata | input | NFUNC*8 | Per-function byte at `cfg_offset`, function i at bits 8i+7:8i |
| cfg_offset | output | 8 | Byte offset within the selected function |
| cfg_wdata | output | 8 | Byte to write into the selected function |
| fn_we | output | NFUNC | One-hot per-function byte write enable |

## Verification
Some properties are checked on every cycle by assertions. These are: the reserved address bits stay clear; `fn_we` is at most one-hot and stays silent when access is disabled or the bus is non-zero; unclaimed writes leave the address register untouched; and `io_rdata` returns to zero after an idle cycle. Other behaviours are shown only by the bench scenarios. These are: lane-selective writes and readback, the offset composed from register and port bits, correct selection of a function's read byte, all-ones returns for absent, out-of-range and other-bus targets, and write dropping for functions whose accept flag is low.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;

    localparam int            IO_AW      = 16;
    localparam logic [15:0]   ADDR_PORT  = 16'h0CF8;
    localparam logic [15:0]   DATA_PORT  = 16'h0CFC;
    localparam logic [31:0]   RSVD_MASK  = 32'h7F00_0003;
    localparam logic [7:0]    ALL_ONES   = 8'hFF;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2
    } port_sel_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [5:0] reg_dw;
    } cfg_tgt_t;

    function automatic port_sel_e classify(input logic [IO_AW-1:0] a);
        if (a[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2])
            return SEL_ADDR;
        else if (a[IO_AW-1:2] == DATA_PORT[IO_AW-1:2])
            return SEL_DATA;
        else
            return SEL_NONE;
    endfunction

    function automatic cfg_tgt_t split_addr(input logic [31:0] r);
        cfg_tgt_t t;
        t.en     = r[31];
        t.bus    = r[23:16];
        t.devfn  = r[15:8];
        t.reg_dw = r[7:2];
        return t;
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
`timescale 1ns/1ps
module cfg_addr_reg
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [1:0]  lane,
    input  logic [7:0]  wdata,
    output logic [31:0] addr_q
);
    localparam int LANES = 4;

    logic [31:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = (lane == 2'(g)) ? wdata : addr_q[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (wr)
            addr_q <= merged & ~RSVD_MASK;
    end

    // R3
    rsvd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (addr_q[30:24] == 7'd0 && addr_q[1:0] == 2'd0));

endmodule

// File: rtl/cfg_decode.sv
`timescale 1ns/1ps
module cfg_decode
    import cfgp_pkg::*;
#(
    parameter int NFUNC = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_tgt_t         tgt,
    input  logic             data_wr,
    input  logic [NFUNC-1:0] fn_wr_accept,
    output logic             routable,
    output logic [NFUNC-1:0] fn_we
);
    logic in_range;

    assign in_range = int'(tgt.devfn) < NFUNC;
    assign routable = tgt.en && (tgt.bus == 8'd0) && in_range;

    for (genvar i = 0; i < NFUNC; i++) begin : g_we
        assign fn_we[i] = data_wr && routable && (tgt.devfn == 8'(i)) && fn_wr_accept[i];
    end

    // R9
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fn_we));

    // R5
    we_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !tgt.en |-> (fn_we == '0));

    // R7
    we_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt.bus != 8'd0) |-> (fn_we == '0));

endmodule

// File: rtl/cfg_read_mux.sv
`timescale 1ns/1ps
module cfg_read_mux
    import cfgp_pkg::*;
#(
    parameter int NFUNC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  port_sel_e          sel,
    input  logic [1:0]         lane,
    input  logic [31:0]        addr_q,
    input  cfg_tgt_t           tgt,
    input  logic               routable,
    input  logic [NFUNC-1:0]   fn_present,
    input  logic [NFUNC*8-1:0] fn_rdata,
    output logic [7:0]         rdata_q
);
    localparam int FW = (NFUNC > 1) ? $clog2(NFUNC) : 1;

    logic [7:0]    fn_byte [NFUNC];
    logic [FW-1:0] idx;
    logic [7:0]    data_byte;
    logic [7:0]    next_byte;

    for (genvar i = 0; i < NFUNC; i++) begin : g_byte
        assign fn_byte[i] = fn_rdata[i*8 +: 8];
    end

    assign idx = tgt.devfn[FW-1:0];

    always_comb begin
        if (routable && fn_present[idx])
            data_byte = fn_byte[idx];
        else
            data_byte = ALL_ONES;
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR: next_byte = addr_q[{lane, 3'b000} +: 8];
            SEL_DATA: next_byte = data_byte;
            default:  next_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= 8'h00;
        else
            rdata_q <= rd ? next_byte : 8'h00;
    end

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata_q == 8'h00));

    // R7
    bus_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_DATA && tgt.bus != 8'd0) |=> (rdata_q == ALL_ONES));

endmodule

// File: rtl/cfg_access_port.sv
`timescale 1ns/1ps
module cfg_access_port
    import cfgp_pkg::*;
#(
    parameter int NFUNC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    input  logic [NFUNC-1:0]   fn_present,
    input  logic [NFUNC-1:0]   fn_wr_accept,
    input  logic [NFUNC*8-1:0] fn_rdata,
    output logic [7:0]         cfg_offset,
    output logic [7:0]         cfg_wdata,
    output logic [NFUNC-1:0]   fn_we
);
    port_sel_e   sel;
    logic [1:0]  lane;
    logic [31:0] addr_q;
    cfg_tgt_t    tgt;
    logic        routable;
    logic        addr_wr;
    logic        data_wr;

    assign sel     = classify(io_addr);
    assign lane    = io_addr[1:0];
    assign tgt     = split_addr(addr_q);
    assign addr_wr = io_wr && (sel == SEL_ADDR);
    assign data_wr = io_wr && (sel == SEL_DATA);

    assign cfg_offset = {tgt.reg_dw, lane};
    assign cfg_wdata  = io_wdata;

    cfg_addr_reg u_areg (
        .clk    (clk),
        .rst    (rst),
        .wr     (addr_wr),
        .lane   (lane),
        .wdata  (io_wdata),
        .addr_q (addr_q)
    );

    cfg_decode #(.NFUNC(NFUNC)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .tgt          (tgt),
        .data_wr      (data_wr),
        .fn_wr_accept (fn_wr_accept),
        .routable     (routable),
        .fn_we        (fn_we)
    );

    cfg_read_mux #(.NFUNC(NFUNC)) u_rmux (
        .clk        (clk),
        .rst        (rst),
        .rd         (io_rd),
        .sel        (sel),
        .lane       (lane),
        .addr_q     (addr_q),
        .tgt        (tgt),
        .routable   (routable),
        .fn_present (fn_present),
        .fn_rdata   (fn_rdata),
        .rdata_q    (io_rdata)
    );

    // R10
    unclaimed_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && sel == SEL_NONE) |=> $stable(addr_q));

    // R10
    unclaimed_nowe_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (fn_we == '0));

endmodule

// File: tb/cfg_access_port_test.sv
`timescale 1ns/1ps
module cfg_access_port_test;

    localparam int NF = 16;
    localparam logic [NF-1:0] PRES = 16'h0203;
    localparam logic [NF-1:0] ACC  = 16'h0201;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   io_addr = '0;
    logic [7:0]    io_wdata = '0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [7:0]    io_rdata;
    logic [NF-1:0] fn_present = PRES;
    logic [NF-1:0] fn_wr_accept = ACC;
    logic [NF*8-1:0] fn_rdata;
    logic [7:0]    cfg_offset;
    logic [7:0]    cfg_wdata;
    logic [NF-1:0] fn_we;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t q[$];

    logic [NF-1:0] last_we;
    logic [7:0]    last_off;
    logic [7:0]    last_wd;

    always #2.5 clk = ~clk;

    cfg_access_port #(.NFUNC(NF)) uut (
        .clk          (clk),
        .rst          (rst),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_rdata     (io_rdata),
        .fn_present   (fn_present),
        .fn_wr_accept (fn_wr_accept),
        .fn_rdata     (fn_rdata),
        .cfg_offset   (cfg_offset),
        .cfg_wdata    (cfg_wdata),
        .fn_we        (fn_we)
    );

    function automatic logic [7:0] pat(input int fn, input logic [7:0] off);
        return 8'(fn * 29) ^ off ^ 8'hA5;
    endfunction

    always_comb begin
        for (int i = 0; i < NF; i++)
            fn_rdata[i*8 +: 8] = pat(i, cfg_offset);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per read response
    bit pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            if (q.size() == 0) begin
                chk(1'b0, "R11 unexpected response", {24'd0, io_rdata}, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(io_rdata == e.exp, e.tag, {24'd0, io_rdata}, {24'd0, e.exp});
            end
        end
        pend = io_rd;
    end

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        last_we = fn_we; last_off = cfg_offset; last_wd = cfg_wdata;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        e.exp = exp; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] v);
        for (int k = 0; k < 4; k++)
            io_write(16'h0CF8 + 16'(k), v[k*8 +: 8]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(fn_we == '0, "R1 fn_we after reset", 32'(fn_we), 32'd0);
        chk(io_rdata == 8'h00, "R1 rdata after reset", {24'd0, io_rdata}, 32'd0);
        for (int k = 0; k < 4; k++)
            io_read(16'h0CF8 + 16'(k), 8'h00, "R1 addr reg lane after reset");
        io_read(16'h0CFC, 8'hFF, "R1 R5 data read while disabled");

        // R3 R4: all ones written
        set_addr(32'hFFFF_FFFF);
        io_read(16'h0CF8, 8'hFC, "R3 lane0 low bits cleared");
        io_read(16'h0CF9, 8'hFF, "R4 lane1 readback");
        io_read(16'h0CFA, 8'hFF, "R4 lane2 readback");
        io_read(16'h0CFB, 8'h80, "R3 lane3 reserved cleared");

        // R2: single-lane update
        io_write(16'h0CF9, 8'h12);
        io_read(16'h0CF9, 8'h12, "R2 written lane");
        io_read(16'h0CF8, 8'hFC, "R2 lane0 kept");
        io_read(16'h0CFA, 8'hFF, "R2 lane2 kept");
        io_read(16'h0CFB, 8'h80, "R2 lane3 kept");

        // R6 R8: device 1 function 1 = index 9, dword 5
        set_addr(32'h8000_0914);
        io_read(16'h0CFE, pat(9, 8'h16), "R6 R8 fn9 offset 0x16");
        io_read(16'h0CFC, pat(9, 8'h14), "R6 R8 fn9 offset 0x14");

        // R9: accepted write
        io_write(16'h0CFD, 8'h3C);
        chk(last_we == NF'(1 << 9), "R9 fn9 write enable", 32'(last_we), 32'(1 << 9));
        chk(last_off == 8'h15, "R6 write offset", {24'd0, last_off}, 32'h15);
        chk(last_wd == 8'h3C, "R9 write data", {24'd0, last_wd}, 32'h3C);

        // R9: present but not accepting
        set_addr(32'h8000_0100);
        io_write(16'h0CFC, 8'h55);
        chk(last_we == '0, "R9 dropped write fn1", 32'(last_we), 32'd0);
        io_read(16'h0CFC, pat(1, 8'h00), "R8 fn1 read");
        io_read(16'h0CFF, pat(1, 8'h03), "R8 R6 fn1 lane3");

        // R8: absent and out-of-range
        set_addr(32'h8000_0200);
        io_read(16'h0CFC, 8'hFF, "R8 absent fn2");
        set_addr(32'h8000_1400);
        io_read(16'h0CFD, 8'hFF, "R8 out-of-range fn20");
        io_write(16'h0CFD, 8'h01);
        chk(last_we == '0, "R8 no write out-of-range", 32'(last_we), 32'd0);

        // R7: non-zero bus
        set_addr(32'h8001_0900);
        io_read(16'h0CFC, 8'hFF, "R7 bus1 read");
        io_write(16'h0CFC, 8'h77);
        chk(last_we == '0, "R7 bus1 write", 32'(last_we), 32'd0);

        // R5: enable clear
        set_addr(32'h0000_0900);
        io_read(16'h0CFC, 8'hFF, "R5 disabled read");
        io_write(16'h0CFC, 8'h77);
        chk(last_we == '0, "R5 disabled write", 32'(last_we), 32'd0);

        // R10: unclaimed ports
        set_addr(32'h8000_0004);
        io_write(16'h0CF4, 8'hAA);
        chk(last_we == '0, "R10 unclaimed write no we", 32'(last_we), 32'd0);
        io_write(16'h0D00, 8'hAA);
        io_read(16'h0CF8, 8'h04, "R10 lane0 unchanged");
        io_read(16'h0CFB, 8'h80, "R10 lane3 unchanged");
        io_read(16'h0CF4, 8'h00, "R10 unclaimed read");
        io_read(16'h0D00, 8'h00, "R10 unclaimed read high");

        // R11: idle after a response returns zero
        io_read(16'h0CF9, 8'h00, "R11 response");
        @(posedge clk); #1;
        @(negedge clk);
        chk(io_rdata == 8'h00, "R11 idle zero", {24'd0, io_rdata}, 32'd0);

        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R11 all responses seen", 32'(q.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule